// File: doc/BRIEF.md
# Serial Debug Line-Reset and Switch-Sequence Detector

This block is a passive observer on a two-wire serial debug bus. The bus clock and data line are sampled in the block's own system clock domain. A double-flop synchroniser and an edge detector recover each rising edge of the bus clock, and the data bit is captured with it. Two detectors work on that stream of bits.

The first detector counts consecutive rising edges on which the data line is high. When the run length reaches fifty edges, the block raises a one-cycle line-reset pulse. It also exposes the running count, which keeps rising past fifty until it saturates. The second detector keeps the last sixteen received bits and compares them, on every edge, against the fixed select sequence 0xE79E sent least significant bit first. On a match it raises a one-cycle pulse.

A transaction decoder placed alongside uses both pulses to resynchronise. The decoder tells this block when it changes protocol state, and that event discards any partial run of high edges.

Top module: `swd_seq_monitor`

## Requirements
- R1: While `rst_n` is low and after it is released, `lr_pulse_o`, `sw_pulse_o` and `lr_count_o` are all zero until a bus-clock rising edge is seen.
- R2: On the 50th consecutive bus-clock rising edge with data high, `lr_pulse_o` is high for exactly one system cycle, and `lr_count_o` reads 50 in that cycle. Only one pulse is produced per unbroken run.
- R3: `lr_count_o` equals the number of consecutive high-data rising edges seen so far. It keeps counting beyond 50 and saturates at 255 (all ones at the default 8-bit width).
- R4: A bus-clock rising edge with data low sets `lr_count_o` to 0. A run of 49 highs, then a low, then 49 highs yields no pulse.
- R5: A one-cycle high on `dec_state_chg_i` sets `lr_count_o` to 0 on the next system clock edge, and counting restarts from zero afterwards.
- R6: When the sixteen most recent rising-edge data bits, first-received bit as bit 0, equal 16'hE79E, `sw_pulse_o` is high for one system cycle and the bit history is cleared.
- R7: Data-line activity with no bus-clock rising edge (clock held at a level) changes neither `lr_count_o` nor either pulse.
- R8: Matching slides over arbitrary leading bits. A sequence differing from 16'hE79E in one bit gives no `sw_pulse_o`.
- R9: Both detectors run regardless of the bus phase. A line reset, then the switch sequence, then another line reset produces two line-reset pulses and one switch pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk_i | input | 1 | Raw bus clock, asynchronous to `clk` |
| bus_dat_i | input | 1 | Raw bus data line |
| dec_state_chg_i | input | 1 | Decoder protocol-state change; clears the high-edge run |
| lr_pulse_o | output | 1 | One-cycle line-reset detection pulse |
| lr_count_o | output | 8 | Current count of consecutive high-data rising edges |
| sw_pulse_o | output | 1 | One-cycle switch-sequence detection pulse |

## Verification
The assertions assume that the bus clock holds each level for at least two system cycles. Under that assumption the recovered rising edge is a single-cycle event, and the data line is stable when it is captured. The bench drives every bus bit with four system cycles in each clock phase. Data changes only while the bus clock is low, and the state-change strobe is applied only between edges. The one exception is the scenario that deliberately toggles data under a static bus clock.

// File: rtl/swd_mon_pkg.sv
package swd_mon_pkg;
  localparam logic [15:0] SWITCH_SEQ_DEFAULT = 16'hE79E;

  // Saturating run-length step: restart on low data, hold at the ceiling.
  function automatic logic [31:0] run_step(input logic [31:0] cnt,
                                           input logic [31:0] ceil,
                                           input logic        hi);
    if (!hi)              return 32'd0;
    else if (cnt >= ceil) return ceil;
    else                  return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/swd_mon_sync.sv
module swd_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk_i,
  input  logic bus_dat_i,
  output logic rise_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_last <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], bus_clk_i};
      dat_pipe <= {dat_pipe[STAGES-2:0], bus_dat_i};
      clk_last <= clk_pipe[STAGES-1];
    end
  end

  assign rise_o = clk_pipe[STAGES-1] & ~clk_last;
  assign dat_o  = dat_pipe[STAGES-1];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/swd_mon_reset_det.sv
module swd_mon_reset_det
  import swd_mon_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int THRESH = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             dat_i,
  input  logic             clr_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt;
  logic             hi_edge;
  logic             lo_edge;
  logic             hit;
  logic [CNT_W-1:0] cnt_nxt;

  assign hi_edge = rise_i & dat_i;
  assign lo_edge = rise_i & ~dat_i;
  assign cnt_nxt = CNT_W'(run_step(32'(cnt), 32'(CNT_MAX), dat_i));
  assign hit     = hi_edge & ~clr_i & (cnt == CNT_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= hit;
      if (clr_i)       cnt <= '0;
      else if (rise_i) cnt <= cnt_nxt;
    end
  end

  assign count_o = cnt;

  AST_PULSE_AT_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (cnt == CNT_HIT)); // R2
  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o); // R2
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_edge && !clr_i && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R3
  AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lo_edge |=> (cnt == '0)); // R4
  AST_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt == '0)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i && !clr_i) |=> $stable(cnt)); // R7
endmodule

// File: rtl/swd_mon_switch_det.sv
module swd_mon_switch_det #(
  parameter int           SEQ_W   = 16,
  parameter logic [SEQ_W-1:0] SEQ_VAL = 16'hE79E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic dat_i,
  output logic pulse_o
);
  logic [SEQ_W-1:0] hist;
  logic [SEQ_W-1:0] hist_shift;
  logic [SEQ_W-1:0] seq_rev;
  logic             hit;

  // Newest bit enters at bit 0, so the first-received bit ends at the top.
  for (genvar i = 0; i < SEQ_W; i++) begin : g_rev
    assign seq_rev[i] = SEQ_VAL[SEQ_W-1-i];
  end

  assign hist_shift = {hist[SEQ_W-2:0], dat_i};
  assign hit        = rise_i & (hist_shift == seq_rev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= hit;
      if (rise_i) hist <= hit ? '0 : hist_shift;
    end
  end

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (hist == '0)); // R6
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(hist)); // R7
endmodule

// File: rtl/swd_seq_monitor.sv
module swd_seq_monitor
  import swd_mon_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int THRESH    = 50,
  parameter int SYNC_STG  = 2,
  parameter int SEQ_W     = 16,
  parameter logic [SEQ_W-1:0] SEQ_VAL = SWITCH_SEQ_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_clk_i,
  input  logic             bus_dat_i,
  input  logic             dec_state_chg_i,
  output logic             lr_pulse_o,
  output logic [CNT_W-1:0] lr_count_o,
  output logic             sw_pulse_o
);
  logic bus_rise;
  logic bus_bit;

  swd_mon_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bus_clk_i(bus_clk_i), .bus_dat_i(bus_dat_i),
    .rise_o(bus_rise), .dat_o(bus_bit)
  );

  swd_mon_reset_det #(.CNT_W(CNT_W), .THRESH(THRESH)) u_reset_det (
    .clk(clk), .rst_n(rst_n),
    .rise_i(bus_rise), .dat_i(bus_bit), .clr_i(dec_state_chg_i),
    .pulse_o(lr_pulse_o), .count_o(lr_count_o)
  );

  swd_mon_switch_det #(.SEQ_W(SEQ_W), .SEQ_VAL(SEQ_VAL)) u_switch_det (
    .clk(clk), .rst_n(rst_n),
    .rise_i(bus_rise), .dat_i(bus_bit),
    .pulse_o(sw_pulse_o)
  );

  AST_PULSES_EXCLUSIVE_OF_RESET: assert property (@(posedge clk)
    !rst_n |=> (!lr_pulse_o && !sw_pulse_o && lr_count_o == '0)); // R1
endmodule

// File: tb/swd_seq_monitor_bench.sv
module swd_seq_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PAT = 16'hE79E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_clk = 1'b0;
  logic       bus_dat = 1'b0;
  logic       chg = 1'b0;
  logic       lr_pulse;
  logic [7:0] lr_count;
  logic       sw_pulse;

  int checks = 0;
  int errors = 0;
  int lr_seen = 0;
  int sw_seen = 0;
  int lr_last = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_seq_monitor u_swd_seq_monitor (
    .clk(clk), .rst_n(rst_n),
    .bus_clk_i(bus_clk), .bus_dat_i(bus_dat), .dec_state_chg_i(chg),
    .lr_pulse_o(lr_pulse), .lr_count_o(lr_count), .sw_pulse_o(sw_pulse)
  );

  always @(negedge clk) begin
    if (lr_pulse) begin
      lr_seen = lr_seen + 1;
      lr_last = int'(lr_count);
    end
    if (sw_pulse) sw_seen = sw_seen + 1;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(posedge clk); #1;
    bus_clk = 1'b0;
    bus_dat = b;
    repeat (4) @(posedge clk);
    #1 bus_clk = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_pat(input logic [15:0] p);
    for (int i = 0; i < 16; i++) send_bit(p[i]);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_eq("R1 count in reset", int'(lr_count), 0);
    check_eq("R1 pulses in reset", int'(lr_pulse) + int'(sw_pulse), 0);
    #1 rst_n = 1'b1;
    settle();
    check_eq("R1 count after release", int'(lr_count), 0);
  endtask

  task automatic t_line_reset();
    int l0;
    l0 = lr_seen;
    send_run(1'b0, 1);
    send_run(1'b1, 49);
    settle();
    check_eq("R2 no pulse at 49", lr_seen - l0, 0);
    send_run(1'b1, 1);
    settle();
    check_eq("R2 one pulse at 50", lr_seen - l0, 1);
    check_eq("R2 count at pulse", lr_last, 50);
    send_run(1'b1, 10);
    settle();
    check_eq("R3 count past 50", int'(lr_count), 60);
    check_eq("R2 single pulse per run", lr_seen - l0, 1);
    send_run(1'b1, 200);
    settle();
    check_eq("R3 saturates", int'(lr_count), 255);
  endtask

  task automatic t_low_clears();
    int l0;
    l0 = lr_seen;
    send_run(1'b0, 1);
    send_run(1'b1, 49);
    settle();
    check_eq("R4 count 49", int'(lr_count), 49);
    send_run(1'b0, 1);
    settle();
    check_eq("R4 low clears", int'(lr_count), 0);
    send_run(1'b1, 49);
    settle();
    check_eq("R4 split run no pulse", lr_seen - l0, 0);
  endtask

  task automatic t_state_change();
    int l0;
    send_run(1'b0, 1);
    l0 = lr_seen;
    send_run(1'b1, 30);
    settle();
    #1 chg = 1'b1;
    @(posedge clk); #1 chg = 1'b0;
    @(negedge clk);
    check_eq("R5 change clears", int'(lr_count), 0);
    send_run(1'b1, 30);
    settle();
    check_eq("R5 restart from zero", int'(lr_count), 30);
    check_eq("R5 no pulse", lr_seen - l0, 0);
  endtask

  task automatic t_switch();
    int s0;
    send_run(1'b0, 16);
    s0 = sw_seen;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_pat(PAT);
    settle();
    check_eq("R6 switch match", sw_seen - s0, 1);
    check_eq("R8 leading bits tolerated", sw_seen - s0, 1);
    send_run(1'b0, 16);
    s0 = sw_seen;
    send_pat(PAT ^ 16'h0100);
    settle();
    check_eq("R8 one-bit mismatch", sw_seen - s0, 0);
  endtask

  task automatic t_static_clock();
    int l0;
    int s0;
    send_run(1'b0, 1);
    send_run(1'b1, 20);
    settle();
    l0 = lr_seen;
    s0 = sw_seen;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1 bus_dat = PAT[i % 16];
    end
    #1 bus_dat = 1'b1;
    settle();
    check_eq("R7 count held", int'(lr_count), 20);
    check_eq("R7 no pulses", (lr_seen - l0) + (sw_seen - s0), 0);
  endtask

  task automatic t_sequence();
    int l0;
    int s0;
    send_run(1'b0, 1);
    l0 = lr_seen;
    s0 = sw_seen;
    send_run(1'b1, 52);
    send_pat(PAT);
    send_run(1'b1, 52);
    settle();
    check_eq("R9 two line resets", lr_seen - l0, 2);
    check_eq("R9 one switch", sw_seen - s0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_line_reset();
    t_low_clears();
    t_state_change();
    t_switch();
    t_static_clock();
    t_sequence();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule